// File: doc/BRIEF.md
# Edge-Selectable Port Input Interrupt

The block watches a group of asynchronous input pins and keeps one sticky interrupt flag per pin. Each pin has a sense bit, which makes the pin either rising-edge sensitive (active level high) or falling-edge sensitive (active level low). It also has an enable bit. Every pin is first brought into the clock domain through a synchroniser. The block then forms a per-pin condition: the synchronised level, XORed with the sense bit, ANDed with the enable bit. A flag sets on any cycle in which that condition goes from 0 to 1.

The flag follows the condition, not the raw pin. An enable or sense write that moves a steady pin into its active state therefore raises a flag just as a real pin edge does. Software clears flags by writing ones, and a single request line reports that at least one flag is set. The processor and the interrupt vectoring logic sit outside the block.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset all flags are 0, `irq_o` is 0, every enable bit is 0 and every sense bit is 0 (rising mode), so pin activity after reset raises no flag until an enable bit is written.
- R2: With sense bit 0 and enable bit 1, a pin going from 0 to 1 sets its flag. The flag (bit i of `flag_o` for pin i) reads 1 on the third rising clock edge after the pin changes: two synchroniser stages plus the flag register.
- R3: With sense bit 1 and enable bit 1, a pin going from 1 to 0 sets its flag, with the same three-edge latency.
- R4: A pin leaving its active level sets no flag, and a pin that stays at its active level does not set the flag again after it has been cleared.
- R5: A pin whose enable bit is 0 never sets its flag, whatever its edges.
- R6: Writing an enable bit from 0 to 1 while the pin is at its active level sets the flag on the clock edge after the write. This holds every time the bit is cleared and set again.
- R7: With the enable bit at 1, rewriting the sense bit so that the pin's present level becomes active sets the flag on the clock edge after the write.
- R8: Writing an enable bit to 1 while the pin is inactive sets no flag. The flag sets only on a later pin edge into the active level.
- R9: Flags are sticky. A clear write with `clr_wdata_i` bit i = 1 clears flag i at that clock edge. Bits written 0 leave their flags unchanged.
- R10: When a flag's set condition and a clear of that same bit fall on the same clock edge, the flag ends up set.
- R11: `irq_o` is the OR of all flags, with no added cycle in the default build. It stays high until every set flag has been cleared.
- R12: Pins are independent. Several pins changing together set exactly the flags whose own conditions rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NUM_PINS | New enable bits, 1 = pin may raise a flag |
| sense_we_i | input | 1 | Write strobe for the sense register |
| sense_wdata_i | input | NUM_PINS | New sense bits, 0 = rising (active high), 1 = falling (active low) |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_wdata_i | input | NUM_PINS | Ones clear the matching flags |
| flag_o | output | NUM_PINS | Sticky per-pin interrupt flags |
| irq_o | output | 1 | OR of all flags |

## Verification
Real pin edges are driven in both sense modes, each toward and away from the active level. This separates true edge detection from level detection, and also catches a reversed sense polarity. A second group of patterns holds the pins still and writes only the enable or sense registers. These show that a flag follows the condition rather than the pin: a write into the active state raises a flag, and a write while the pin is inactive does not. Clear writes are placed on the very edge where a flag sets, which shows whether set or clear takes priority. A final group switches several pins at once to expose any coupling between bits. The latency in every pattern is counted exactly, so an extra or missing register stage shows up as a check failure.

// File: rtl/pei_pkg.sv
package pei_pkg;

   // Sense encoding of one pin.
   typedef enum logic {
      SENSE_RISE = 1'b0,
      SENSE_FALL = 1'b1
   } sense_e;

   // Returns 1 when the parameter set is usable.
   function automatic bit params_ok(input int pins, input int stages);
      return (pins >= 1) && (pins <= 64) && (stages >= 2) && (stages <= 8);
   endfunction

   // Active condition of one pin from its level, sense and enable.
   function automatic logic pin_active(input logic level, input sense_e sense,
                                       input logic enable);
      return (level ^ logic'(sense)) & enable;
   endfunction

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pei_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[LAST];

   // R2: the output only ever takes the value the stage before it held one cycle earlier
   a_r2_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stage_q[LAST] == $past(stage_q[LAST-1])));

endmodule

// File: rtl/pei_cfg_regs.sv
module pei_cfg_regs #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_we_i,
   input  logic [WIDTH-1:0] en_wdata_i,
   input  logic             sense_we_i,
   input  logic [WIDTH-1:0] sense_wdata_i,
   output logic [WIDTH-1:0] en_o,
   output logic [WIDTH-1:0] sense_o
);

   logic [WIDTH-1:0] en_q;
   logic [WIDTH-1:0] sense_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_we_i) en_q <= en_wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sense_q <= '0;
      else if (sense_we_i) sense_q <= sense_wdata_i;
   end

   assign en_o    = en_q;
   assign sense_o = sense_q;

   // R6: enable bits change only through a write
   a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we_i |=> $stable(en_q));

   // R7: sense bits change only through a write
   a_r7_sense_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_we_i |=> $stable(sense_q));

   // R1: a write lands in the register on the next edge
   a_r1_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
      en_we_i |=> (en_q == $past(en_wdata_i)));

endmodule

// File: rtl/pei_flag_cell.sv
module pei_flag_cell
   import pei_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   level_i,
   input  sense_e sense_i,
   input  logic   en_i,
   input  logic   clr_i,
   output logic   flag_o
);

   logic cond_w;
   logic cond_q;
   logic set_w;
   logic flag_q;

   assign cond_w = pin_active(level_i, sense_i, en_i);
   assign set_w  = cond_w & ~cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond_w;
   end

   // Set has priority over clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_w) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R5: with the enable bit low a clear flag stays clear
   a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !flag_q) |=> !flag_q);

   // R9: a flag with no clear request stays set
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);

   // R9: a clear with no competing set empties the flag
   a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(cond_w && !cond_q)) |=> !flag_q);

   // R10: a rising condition beats a clear on the same edge
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_w && !cond_q && clr_i) |=> flag_q);

   // R2: a flag never rises without the condition having risen
   a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(cond_w && !cond_q));

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
   import pei_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                en_we_i,
   input  logic [NUM_PINS-1:0] en_wdata_i,
   input  logic                sense_we_i,
   input  logic [NUM_PINS-1:0] sense_wdata_i,
   input  logic                clr_we_i,
   input  logic [NUM_PINS-1:0] clr_wdata_i,
   output logic [NUM_PINS-1:0] flag_o,
   output logic                irq_o
);

   localparam int W = NUM_PINS;

   if (!params_ok(NUM_PINS, SYNC_STAGES)) begin : g_bad_params
      $error("pin_edge_irq: NUM_PINS must be 1..64 and SYNC_STAGES 2..8");
   end

   logic [W-1:0] level_w;
   logic [W-1:0] en_w;
   logic [W-1:0] sense_w;
   logic [W-1:0] clr_w;
   logic [W-1:0] flags_w;

   pei_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (level_w)
   );

   pei_cfg_regs #(.WIDTH(W)) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_we_i       (en_we_i),
      .en_wdata_i    (en_wdata_i),
      .sense_we_i    (sense_we_i),
      .sense_wdata_i (sense_wdata_i),
      .en_o          (en_w),
      .sense_o       (sense_w)
   );

   assign clr_w = clr_wdata_i & {W{clr_we_i}};

   for (genvar i = 0; i < W; i++) begin : g_pin
      pei_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .level_i (level_w[i]),
         .sense_i (sense_e'(sense_w[i])),
         .en_i    (en_w[i]),
         .clr_i   (clr_w[i]),
         .flag_o  (flags_w[i])
      );
   end

   assign flag_o = flags_w;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |flags_w;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |flags_w;

      // R11: the request cannot drop unless some clear was written
      a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_o && !(clr_we_i && (|clr_wdata_i))) |=> irq_o);
   end

   // R1: nothing is flagged while all enables are still at their reset value
   a_r1_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_w == '0) && (flag_o == '0)) |=> (flag_o == '0));

endmodule

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin = '0;
   logic         en_we = 1'b0;
   logic [N-1:0] en_wd = '0;
   logic         sense_we = 1'b0;
   logic [N-1:0] sense_wd = '0;
   logic         clr_we = 1'b0;
   logic [N-1:0] clr_wd = '0;
   logic [N-1:0] flag;
   logic         irq;

   always #10 clk = ~clk;

   pin_edge_irq #(.NUM_PINS(N), .SYNC_STAGES(2), .IRQ_REG(1'b0)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .pin_i         (pin),
      .en_we_i       (en_we),
      .en_wdata_i    (en_wd),
      .sense_we_i    (sense_we),
      .sense_wdata_i (sense_wd),
      .clr_we_i      (clr_we),
      .clr_wdata_i   (clr_wd),
      .flag_o        (flag),
      .irq_o         (irq)
   );

   typedef struct {
      int           due;
      logic [N-1:0] flags;
      string        tag;
   } exp_t;

   exp_t sbq[$];
   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   bit   finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pops expectations that fall due and compares them.
   always @(negedge clk) begin
      #1;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         exp_t e;
         e = sbq.pop_front();
         checks++;
         if (e.due < cyc) begin
            failures++;
            $display("FAIL %s: expectation missed at cycle %0d (actual %b expected %b)",
                     e.tag, cyc, flag, e.flags);
         end else if (flag !== e.flags) begin
            failures++;
            $display("FAIL %s: flags actual %b expected %b at cycle %0d",
                     e.tag, flag, e.flags, cyc);
         end
         checks++;
         if (irq !== (|e.flags)) begin
            failures++;
            $display("FAIL R11: irq actual %b expected %b at cycle %0d (%s)",
                     irq, |e.flags, cyc, e.tag);
         end
      end
   end

   task automatic expect_in(input int k, input logic [N-1:0] f, input string tag);
      exp_t e;
      e.due = cyc + k;
      e.flags = f;
      e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_en(input logic [N-1:0] v);
      en_we = 1'b1; en_wd = v;
      @(negedge clk);
      en_we = 1'b0;
   endtask

   task automatic wr_sense(input logic [N-1:0] v);
      sense_we = 1'b1; sense_wd = v;
      @(negedge clk);
      sense_we = 1'b0;
   endtask

   task automatic wr_clr(input logic [N-1:0] v);
      clr_we = 1'b1; clr_wd = v;
      @(negedge clk);
      clr_we = 1'b0; clr_wd = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      expect_in(1, 4'b0000, "R1 reset state");
      tick(2);

      // R1/R5: pins rise with every enable bit still at reset value 0
      pin = 4'b1111;
      expect_in(3, 4'b0000, "R5 disabled pin edge");
      expect_in(5, 4'b0000, "R1 enable reset to zero");
      tick(6);

      // R6: enable written while pin 0 is already high (rising mode)
      expect_in(0, 4'b0000, "R6 before enable");
      wr_en(4'b0001);
      expect_in(0, 4'b0000, "R6 not before next edge");
      expect_in(1, 4'b0001, "R6 enable into active level");
      tick(2);
      wr_clr(4'b0001);
      expect_in(0, 4'b0000, "R9 clear by one");
      expect_in(3, 4'b0000, "R4 steady active level no retrigger");
      tick(4);

      // R6: clear and set the enable again while still active
      wr_en(4'b0000);
      tick(2);
      wr_en(4'b0001);
      expect_in(1, 4'b0001, "R6 re-enable sets again");
      tick(2);
      wr_clr(4'b0001);
      expect_in(0, 4'b0000, "R9 clear");
      tick(1);

      // R4: leaving the active level is not an event
      pin = 4'b0000;
      expect_in(3, 4'b0000, "R4 falling edge in rising mode");
      expect_in(5, 4'b0000, "R4 falling edge in rising mode");
      tick(6);

      // R8: enable while inactive, then a real edge
      wr_en(4'b0011);
      expect_in(1, 4'b0000, "R8 enable while inactive");
      expect_in(3, 4'b0000, "R8 enable while inactive");
      tick(4);
      pin = 4'b0010;
      expect_in(2, 4'b0000, "R2 latency not yet");
      expect_in(3, 4'b0010, "R2 rising edge flag");
      tick(8);

      // R9: sticky, zero bits ignored, one bit clears
      expect_in(0, 4'b0010, "R9 sticky");
      wr_clr(4'b0001);
      expect_in(0, 4'b0010, "R9 zero bit ignored");
      tick(1);
      wr_clr(4'b0010);
      expect_in(0, 4'b0000, "R9 clear");
      tick(1);

      // R7: sense rewrite makes low pin 0 active
      wr_sense(4'b0011);
      expect_in(1, 4'b0001, "R7 sense rewrite into active");
      tick(2);
      wr_clr(4'b0001);
      expect_in(0, 4'b0000, "R9 clear");
      tick(1);

      // R3: falling edge on pin 1 in falling mode
      pin = 4'b0000;
      expect_in(2, 4'b0000, "R3 latency not yet");
      expect_in(3, 4'b0010, "R3 falling edge flag");
      tick(4);
      wr_clr(4'b0010);
      pin = 4'b0010;
      expect_in(3, 4'b0000, "R4 rising edge in falling mode");
      expect_in(5, 4'b0000, "R4 rising edge in falling mode");
      tick(6);

      // R10: set and clear of pin 0 on the same edge
      pin = 4'b0011;
      tick(4);
      pin = 4'b0010;
      tick(2);
      wr_clr(4'b0001);
      expect_in(0, 4'b0001, "R10 set wins over clear");
      tick(1);

      // R11: request holds until the last flag is cleared
      pin = 4'b0000;
      expect_in(3, 4'b0011, "R11 two flags");
      tick(4);
      wr_clr(4'b0001);
      expect_in(0, 4'b0010, "R11 irq holds with one flag");
      tick(1);
      wr_clr(4'b0010);
      expect_in(0, 4'b0000, "R11 irq drops");
      tick(1);

      // R12: several pins at once, rising mode
      wr_en(4'b0000);
      wr_sense(4'b0000);
      tick(4);
      wr_en(4'b1111);
      expect_in(1, 4'b0000, "R12 all enabled while inactive");
      tick(2);
      pin = 4'b0101;
      expect_in(3, 4'b0101, "R12 two pins rise together");
      tick(4);
      pin = 4'b1111;
      expect_in(3, 4'b1111, "R12 other two pins rise");
      tick(5);

      if (sbq.size() != 0) begin
         checks++;
         failures++;
         $display("FAIL scoreboard: %0d expectations left (expected 0)", sbq.size());
      end
      finish_run();
   end

endmodule